// File: doc/BRIEF.md
# Character Glyph Row Fetch with Cursor Merge

This block returns the five dots of one row of one character cell for a character display pipeline. On each clock it takes a character code, a row index from 0 to 7, the display address of the cell being drawn, the cursor address and a cursor enable. One clock later it presents a registered 5-bit dot row.

Codes whose upper four bits are all zero read from a small writable glyph store. The store holds eight user glyphs of eight rows each, and a host loads it one row at a time through a write port. Every other code reads from a fixed pattern table. Here that table is a synthesizable stand-in that computes its rows from a formula, so a full font is not needed.

Row 7 is the underline row. When the cell being drawn is the cursor cell and the cursor is enabled, that row is ORed with a solid line. The stored dots are never replaced.

Top module: `glyph_row_fetch`

## Requirements
- R1: While `rst_n` is low at a clock edge, `dots` becomes 0 and every row of the glyph store is cleared to 0.
- R2: `dots` after a rising edge is computed from the request inputs sampled at that edge, which gives one cycle of latency.
- R3: A code with bits 7:4 equal to 0 reads the glyph store at address {code[2:0], row}, where code bits 2:0 are address bits 5:3 and the row index is address bits 2:0.
- R4: Code bit 3 is ignored on a glyph-store read, so code n and code n+8 (n from 0 to 7) give the same rows.
- R5: A host write stores `host_wdata[4:0]` at `host_addr`. Bits 7:5 of the write data are discarded. In the output, bit 4 is the leftmost dot and 1 means lit.
- R6: A code with bits 7:4 not all zero reads the fixed table, whose row is code[4:0] XOR {row, 2'b00}.
- R7: When `cursor_en` is 1, `cell_addr` equals `cursor_addr` and the row is 7, the output is 5'b11111, ORed over the stored row.
- R8: Outside the cursor case of R7 the output is the looked-up row unchanged. This means stored 1s in row 7 are lit with no cursor present, and rows 0 to 6 of the cursor cell are not altered.
- R9: A read and a write to the same store address on the same edge return the old contents. The new row is visible from the next request on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Glyph store write strobe |
| host_addr | input | 6 | Glyph store address {slot, row} |
| host_wdata | input | 8 | Write data; bits 4:0 are stored |
| char_code | input | 8 | Character code of the cell |
| row_idx | input | 3 | Row within the cell, 0 at the top |
| cell_addr | input | 7 | Display address of the cell |
| cursor_addr | input | 7 | Display address of the cursor |
| cursor_en | input | 1 | Cursor line enable |
| dots | output | 5 | Registered dot row, bit 4 leftmost |

## Verification
A corrupted glyph store row shows up at `dots` on the first read of that slot and row, exactly one cycle after the request. Because bit 3 is ignored, both aliasing codes return the same wrong row. A wrong source select or a wrong address split makes store rows and fixed-table rows swap or shift between slots. The random reads sweep every slot and row, so that kind of fault appears within a few hundred cycles. A fault in the cursor logic is visible only on row 7 of the matching cell, so directed cases cover the match and near-miss cases of the address and enable, and also row 7 with the cursor off.

// File: rtl/glyph_pkg.sv
// Package: shared widths and the fixed pattern table stand-in.
// Assumes 8-bit character codes and 5-dot rows of 8 rows per glyph.
package glyph_pkg;
    localparam int CODE_W  = 8;
    localparam int DOT_W   = 5;
    localparam int ROW_W   = 3;
    localparam int SLOT_W  = 3;
    localparam int STORE_AW = SLOT_W + ROW_W;
    localparam int HOST_DW = 8;
    localparam int CELL_AW = 7;
    localparam logic [ROW_W-1:0] CURSOR_ROW = 3'd7;

    // Fixed table stand-in: a deterministic row per code and row.
    function automatic logic [DOT_W-1:0] fixed_row(
        input logic [CODE_W-1:0] code,
        input logic [ROW_W-1:0]  row
    );
        return code[DOT_W-1:0] ^ {row, 2'b00};
    endfunction
endpackage

// File: rtl/glyph_store.sv
// Module: glyph_store
// Writable store of user glyph rows with one write port and one
// combinational read port. A read on a write edge returns the old row,
// because the consumer registers rdata on that same edge.
// Assumes a synchronous active-low reset that clears every row.
module glyph_store #(
    parameter int AW  = 6,
    parameter int DW  = 5,
    parameter int HDW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [AW-1:0]  waddr,
    input  logic [HDW-1:0] wdata,
    input  logic [AW-1:0]  raddr,
    output logic [DW-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Clear on reset, otherwise store the low data bits on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata[DW-1:0];
        end
    end

    // Combinational read of the addressed row.
    assign rdata = mem[raddr];

    // R5: a written row holds the low data bits on the next cycle.
    p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(waddr)] == $past(wdata[DW-1:0]));

    // R1: reset leaves row 0 cleared.
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> mem[0] == '0);
endmodule

// File: rtl/glyph_source_sel.sv
// Module: glyph_source_sel
// Decodes a character code and row into a store address and a source
// choice. The store is chosen when the top four code bits are zero.
// Code bit 3 does not take part in the store address.
module glyph_source_sel
    import glyph_pkg::*;
(
    input  logic [CODE_W-1:0]   code,
    input  logic [ROW_W-1:0]    row,
    output logic                use_store,
    output logic [STORE_AW-1:0] store_addr
);
    // Pick the source and build {slot, row}.
    always_comb begin
        use_store  = (code[CODE_W-1:4] == '0);
        store_addr = {code[SLOT_W-1:0], row};
    end
endmodule

// File: rtl/glyph_cursor.sv
// Module: glyph_cursor
// Flags when the underline row of the cursor cell is being drawn.
module glyph_cursor
    import glyph_pkg::*;
(
    input  logic [CELL_AW-1:0] cell_addr,
    input  logic [CELL_AW-1:0] cursor_addr,
    input  logic               cursor_en,
    input  logic [ROW_W-1:0]   row,
    output logic               line_on
);
    // Enabled, on the cursor cell, and on the underline row.
    always_comb begin
        line_on = cursor_en && (cell_addr == cursor_addr) && (row == CURSOR_ROW);
    end
endmodule

// File: rtl/glyph_row_fetch.sv
// Module: glyph_row_fetch (top)
// Returns the registered 5-dot row of one character cell. The row comes
// from the user glyph store or from the fixed table, and the cursor line
// is ORed in on row 7. Latency is one clock.
// Assumes synchronous active-low reset and a single clock.
module glyph_row_fetch
    import glyph_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_we,
    input  logic [STORE_AW-1:0] host_addr,
    input  logic [HOST_DW-1:0]  host_wdata,
    input  logic [CODE_W-1:0]   char_code,
    input  logic [ROW_W-1:0]    row_idx,
    input  logic [CELL_AW-1:0]  cell_addr,
    input  logic [CELL_AW-1:0]  cursor_addr,
    input  logic                cursor_en,
    output logic [DOT_W-1:0]    dots
);
    logic                use_store;
    logic [STORE_AW-1:0] store_addr;
    logic [DOT_W-1:0]    store_row;
    logic [DOT_W-1:0]    table_row;
    logic                line_on;
    logic [DOT_W-1:0]    row_next;
    logic [DOT_W-1:0]    dots_q;

    glyph_source_sel u_sel (
        .code       (char_code),
        .row        (row_idx),
        .use_store  (use_store),
        .store_addr (store_addr)
    );

    glyph_store #(
        .AW  (STORE_AW),
        .DW  (DOT_W),
        .HDW (HOST_DW)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (host_we),
        .waddr (host_addr),
        .wdata (host_wdata),
        .raddr (store_addr),
        .rdata (store_row)
    );

    glyph_cursor u_cursor (
        .cell_addr   (cell_addr),
        .cursor_addr (cursor_addr),
        .cursor_en   (cursor_en),
        .row         (row_idx),
        .line_on     (line_on)
    );

    // Pick the source row and OR in the cursor line.
    always_comb begin
        table_row = fixed_row(char_code, row_idx);
        row_next  = (use_store ? store_row : table_row)
                    | {DOT_W{line_on}};
    end

    // Register the output row.
    always_ff @(posedge clk) begin
        if (!rst_n) dots_q <= '0;
        else        dots_q <= row_next;
    end

    assign dots = dots_q;

    // R1: reset drives the output to zero.
    p_reset_dark_r1: assert property (@(posedge clk)
        !rst_n |=> dots == '0);

    // R7: a cursor hit lights the whole row on the next cycle.
    p_cursor_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        line_on |=> dots == {DOT_W{1'b1}});

    // R6: a fixed-table read without a cursor hit returns the table row.
    p_table_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!use_store && !line_on) |=> dots == $past(table_row));

    // R3: a store read without a cursor hit returns the store row.
    p_store_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (use_store && !line_on) |=> dots == $past(store_row));
endmodule

// File: tb/glyph_row_fetch_tb.sv
// Bench: directed corner cases plus seeded random traffic against a
// model store kept in the bench. Inputs change on the falling edge, and
// outputs are checked on the falling edge one cycle after the request.
module glyph_row_fetch_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_we = 1'b0;
    logic [5:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] char_code = '0;
    logic [2:0] row_idx = '0;
    logic [6:0] cell_addr = '0;
    logic [6:0] cursor_addr = '0;
    logic       cursor_en = 1'b0;
    logic [4:0] dots;

    int checks = 0;
    int errors = 0;
    logic [4:0] model [64];

    always #10 clk = ~clk;

    glyph_row_fetch u_dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .char_code(char_code), .row_idx(row_idx),
        .cell_addr(cell_addr), .cursor_addr(cursor_addr),
        .cursor_en(cursor_en), .dots(dots)
    );

    // Expected row from the requirements, using the model store.
    function automatic logic [4:0] expect_row(
        input logic [7:0] c, input logic [2:0] r, input logic [6:0] ca,
        input logic [6:0] cu, input logic en
    );
        logic [4:0] base;
        if (c[7:4] == 4'h0) base = model[{c[2:0], r}];      // R3, R4
        else                base = c[4:0] ^ {r, 2'b00};    // R6
        if (en && ca == cu && r == 3'd7) base = base | 5'h1f; // R7
        return base;
    endfunction

    task automatic check(input logic [4:0] exp, input string tag);
        checks++;
        if (dots !== exp) begin
            errors++;
            $display("FAIL %s: dots=%h expected=%h", tag, dots, exp);
        end
    endtask

    // One request cycle: drive at the falling edge, check one cycle later.
    task automatic cycle(input logic we, input logic [5:0] wa,
                         input logic [7:0] wd, input logic [7:0] c,
                         input logic [2:0] r, input logic [6:0] ca,
                         input logic [6:0] cu, input logic en,
                         input string tag);
        logic [4:0] exp;
        host_we = we; host_addr = wa; host_wdata = wd;
        char_code = c; row_idx = r; cell_addr = ca;
        cursor_addr = cu; cursor_en = en;
        exp = expect_row(c, r, ca, cu, en);   // old contents (R9)
        if (we) model[wa] = wd[4:0];           // R5
        @(negedge clk);
        check(exp, tag);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) model[i] = 5'h00;
        repeat (3) @(negedge clk);
        checks++;
        if (dots !== 5'h00) begin
            errors++;
            $display("FAIL R1: dots=%h expected=00", dots);
        end
        rst_n = 1'b1;
        // R1: store cleared by reset.
        cycle(0, 0, 0, 8'h00, 3'd0, 7'd0, 7'd1, 0, "R1 store clear");
        // R5: upper write bits discarded; R8 stored row 7 lit without cursor.
        cycle(1, 6'h17, 8'hEA, 8'h41, 3'd0, 7'd0, 7'd1, 0, "R6 fixed 41/0");
        cycle(0, 0, 0, 8'h02, 3'd7, 7'd5, 7'd6, 0, "R5 R8 row7 no cursor");
        // R4: code 0A aliases 02.
        cycle(0, 0, 0, 8'h0A, 3'd7, 7'd5, 7'd6, 0, "R4 alias 0A");
        // R7: cursor hit ORs the line in.
        cycle(0, 0, 0, 8'h02, 3'd7, 7'd9, 7'd9, 1, "R7 cursor hit");
        // R8: cursor cell on another row is unchanged.
        cycle(1, 6'h13, 8'h11, 8'h00, 3'd0, 7'd9, 7'd9, 1, "R8 prep");
        cycle(0, 0, 0, 8'h0A, 3'd3, 7'd9, 7'd9, 1, "R8 cursor row3");
        // R8: address mismatch, then enable low.
        cycle(0, 0, 0, 8'h02, 3'd7, 7'd8, 7'd9, 1, "R8 miss addr");
        cycle(0, 0, 0, 8'h02, 3'd7, 7'd9, 7'd9, 0, "R8 cursor off");
        // R6: fixed table row 5 of 41 -> 15.
        cycle(0, 0, 0, 8'h41, 3'd5, 7'd0, 7'd1, 0, "R6 fixed 41/5");
        // R9: same-edge write and read returns old, next sees new.
        cycle(1, 6'h2C, 8'h1F, 8'h05, 3'd4, 7'd0, 7'd1, 0, "R9 old row");
        cycle(0, 0, 0, 8'h05, 3'd4, 7'd0, 7'd1, 0, "R9 new row");
        // R2 R3: seeded random traffic.
        void'($urandom(32'd2024));
        for (int k = 0; k < 3000; k++) begin
            logic [7:0] c;
            c = $urandom;
            if ($urandom % 2) c[7:4] = 4'h0;
            cycle($urandom % 3 == 0, 6'($urandom), 8'($urandom), c,
                  3'($urandom), 7'($urandom % 4), 7'($urandom % 4),
                  1'($urandom), "R2 R3 random");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: run did not end, expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule